// File: doc/BRIEF.md
# Lane-partitioned logical shifter

This block shifts a 16-bit word as one, two or four independent lanes. A 3-bit partition code picks the lane layout. A direction input picks a left or a right logical shift. A mode input says where each lane's shift count comes from. In per-lane mode, every lane reads its own count from operand B at that lane's position. In common mode, every lane uses the same count, taken from the bottom of B. Each count is reduced to the width of its lane.

Every shift keeps to its lane. Positions that a shift empties are filled with zeros. A bit pushed past either edge of its lane is lost and never reaches the lane next to it. The block has no clock and no state, and the result follows the inputs within the same cycle. The datapath is a chain of binary-weighted mux stages. At each stage, a boundary test against each bit's offset inside its lane blocks any move across an active partition point.

Top module: `psh_shifter`

## Requirements
- R1: With `dir_right_i` = 0, each lane is shifted towards its most significant bit, and the vacated low positions of the lane are 0.
- R2: With `dir_right_i` = 1, each lane is shifted towards its least significant bit, and the vacated high positions of the lane are 0.
- R3: Partition bit i marks a lane boundary at result bit 4*(i+1). Code 3'b000 gives one 16-bit lane. Code 3'b010 gives two 8-bit lanes. Code 3'b111 gives four 4-bit lanes.
- R4: Any partition code other than 3'b000, 3'b010 and 3'b111 behaves exactly like 3'b000, which is one 16-bit lane.
- R5: With `scalar_i` = 0, a lane's shift count is the value of B starting at that lane's lowest bit, ANDed with (lane width - 1). The mask is 15 for a 16-bit lane, 7 for an 8-bit lane and 3 for a 4-bit lane.
- R6: With `scalar_i` = 1, every lane's count is B[3:0] ANDed with (lane width - 1) of that lane. All other bits of B have no effect.
- R7: Bits shifted past the top or the bottom of a lane are discarded and never appear in another lane.
- R8: A lane whose effective count is 0 passes its input bits through unchanged, and an all-zero A gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | Data word to be shifted |
| opb_i | input | 16 | Shift count source: one count per lane, or a single count in its low bits |
| part_i | input | 3 | Partition code; bit i cuts the word at bit 4*(i+1) |
| dir_right_i | input | 1 | 0 shifts left, 1 shifts right (logical) |
| scalar_i | input | 1 | 1 uses one common count for all lanes, 0 uses a count per lane |
| result_o | output | 16 | Shifted word |

## Verification
The assertions check three things on every evaluation:
- Every derived lane count stays below its lane width.
- In common mode, all lanes receive the same count.
- A lane's output never holds more set bits than its input, so no bit can enter from a neighbour.

They also confirm that zero counts and zero data pass through unchanged. Only the bench can show the exact bit placement for each direction, mode and partition code. That includes the fallback of undefined codes to a single lane and the choice of which B bits feed which lane. The bench compares these against a lane-by-lane arithmetic model, across all eight codes and a sweep of operand values.

// File: rtl/psh_pkg.sv
package psh_pkg;

   // Lane layouts the shifter understands.
   typedef enum logic [1:0] {
      LCFG_FULL  = 2'd0,
      LCFG_HALF  = 2'd1,
      LCFG_CHUNK = 2'd2
   } lane_cfg_e;

endpackage

// File: rtl/psh_lane_decode.sv
module psh_lane_decode
   import psh_pkg::*;
#(
   parameter int unsigned N_CHUNKS = 4,
   localparam int unsigned CUT_W = N_CHUNKS - 1
) (
   input  logic [CUT_W-1:0] part_i,
   output lane_cfg_e        cfg_o
);

   // Only the middle cut set: the word splits into two halves.
   localparam logic [CUT_W-1:0] HALF_CODE = CUT_W'(1) << (N_CHUNKS / 2 - 1);

   always_comb begin
      if (part_i == '1)
         cfg_o = LCFG_CHUNK;
      else if (part_i == HALF_CODE)
         cfg_o = LCFG_HALF;
      else
         cfg_o = LCFG_FULL;   // undefined codes fold onto one lane
   end

endmodule

// File: rtl/psh_amount.sv
module psh_amount
   import psh_pkg::*;
#(
   parameter int unsigned CHUNK_W  = 4,
   parameter int unsigned N_CHUNKS = 4,
   localparam int unsigned WIDTH = CHUNK_W * N_CHUNKS,
   localparam int unsigned SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]                opb_i,
   input  logic                            scalar_i,
   input  lane_cfg_e                       cfg_i,
   output logic [SHW:0]                    lane_w_o,
   output logic [N_CHUNKS-1:0][SHW-1:0]    amt_o
);

   localparam logic [SHW:0] W_FULL  = (SHW+1)'(WIDTH);
   localparam logic [SHW:0] W_HALF  = (SHW+1)'(WIDTH / 2);
   localparam logic [SHW:0] W_CHUNK = (SHW+1)'(CHUNK_W);

   logic [SHW-1:0] lane_mask;

   always_comb begin
      unique case (cfg_i)
         LCFG_CHUNK: lane_w_o = W_CHUNK;
         LCFG_HALF:  lane_w_o = W_HALF;
         default:    lane_w_o = W_FULL;
      endcase
   end

   // Lane widths are powers of two, so width-1 is a contiguous mask.
   assign lane_mask = lane_w_o[SHW-1:0] - SHW'(1);

   for (genvar c = 0; c < N_CHUNKS; c++) begin : g_chunk
      localparam int unsigned LO_CHUNK = c * CHUNK_W;
      localparam int unsigned LO_HALF  = (c >= N_CHUNKS / 2) ? WIDTH / 2 : 0;

      logic [WIDTH-1:0] src;
      logic [SHW-1:0]   amt_c;

      always_comb begin
         if (scalar_i)
            src = opb_i;
         else begin
            unique case (cfg_i)
               LCFG_CHUNK: src = opb_i >> LO_CHUNK;
               LCFG_HALF:  src = opb_i >> LO_HALF;
               default:    src = opb_i;
            endcase
         end
         amt_c = src[SHW-1:0] & lane_mask;
      end

      assign amt_o[c] = amt_c;

      always_comb begin
         p_amt_below_lane_r5: assert ({1'b0, amt_o[c]} < lane_w_o)
            else $error("lane count %0d not below lane width %0d", amt_o[c], lane_w_o);
         if (scalar_i && c > 0)
            p_scalar_uniform_r6: assert (amt_o[c] == amt_o[0])
               else $error("common mode gave differing counts");
      end
   end

endmodule

// File: rtl/psh_stage.sv
module psh_stage #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned STAGE = 0,
   localparam int unsigned SHW  = $clog2(WIDTH),
   localparam int unsigned DIST = 1 << STAGE
) (
   input  logic [WIDTH-1:0]            din_i,
   input  logic [WIDTH-1:0]            step_i,
   input  logic [WIDTH-1:0][SHW-1:0]   pos_i,
   input  logic [SHW:0]                lane_w_i,
   input  logic                        dir_right_i,
   output logic [WIDTH-1:0]            dout_o
);

   localparam logic [SHW:0] DIST_V = (SHW+1)'(DIST);

   for (genvar j = 0; j < WIDTH; j++) begin : g_bit
      logic from_lo;
      logic from_hi;

      // Source below: valid only if it sits in the same lane.
      if (j >= DIST) begin : g_lo
         assign from_lo = din_i[j-DIST] & ({1'b0, pos_i[j]} >= DIST_V);
      end else begin : g_lo_edge
         assign from_lo = 1'b0;
      end

      // Source above: valid only if it stays below the lane top.
      if (j + DIST < WIDTH) begin : g_hi
         assign from_hi = din_i[j+DIST] & (({1'b0, pos_i[j]} + DIST_V) < lane_w_i);
      end else begin : g_hi_edge
         assign from_hi = 1'b0;
      end

      assign dout_o[j] = step_i[j] ? (dir_right_i ? from_hi : from_lo) : din_i[j];
   end

endmodule

// File: rtl/psh_shifter.sv
module psh_shifter
   import psh_pkg::*;
#(
   parameter int unsigned CHUNK_W  = 4,
   parameter int unsigned N_CHUNKS = 4,
   localparam int unsigned WIDTH = CHUNK_W * N_CHUNKS,
   localparam int unsigned CUT_W = N_CHUNKS - 1
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [CUT_W-1:0] part_i,
   input  logic             dir_right_i,
   input  logic             scalar_i,
   output logic [WIDTH-1:0] result_o
);

   localparam int unsigned SHW   = $clog2(WIDTH);
   localparam int unsigned HALF  = WIDTH / 2;

   // Elaboration-time parameter checks.
   if ((CHUNK_W < 2) || ((CHUNK_W & (CHUNK_W - 1)) != 0)) begin : g_bad_chunk
      $error("CHUNK_W must be a power of two of at least 2");
   end
   if ((N_CHUNKS < 2) || ((N_CHUNKS & (N_CHUNKS - 1)) != 0)) begin : g_bad_count
      $error("N_CHUNKS must be a power of two of at least 2");
   end

   lane_cfg_e                      cfg;
   logic [SHW:0]                   lane_w;
   logic [SHW-1:0]                 lane_mask;
   logic [N_CHUNKS-1:0][SHW-1:0]   amt;
   logic [WIDTH-1:0][SHW-1:0]      pos;
   logic [SHW-1:0][WIDTH-1:0]      step;
   logic [SHW:0][WIDTH-1:0]        stage_data;

   psh_lane_decode #(
      .N_CHUNKS (N_CHUNKS)
   ) u_decode (
      .part_i (part_i),
      .cfg_o  (cfg)
   );

   psh_amount #(
      .CHUNK_W  (CHUNK_W),
      .N_CHUNKS (N_CHUNKS)
   ) u_amount (
      .opb_i    (opb_i),
      .scalar_i (scalar_i),
      .cfg_i    (cfg),
      .lane_w_o (lane_w),
      .amt_o    (amt)
   );

   assign lane_mask = lane_w[SHW-1:0] - SHW'(1);

   // Offset of every bit inside its own lane.
   for (genvar j = 0; j < WIDTH; j++) begin : g_pos
      assign pos[j] = SHW'(j) & lane_mask;
   end

   // Per-bit stage enables from the owning chunk's count.
   for (genvar s = 0; s < SHW; s++) begin : g_step
      for (genvar j = 0; j < WIDTH; j++) begin : g_bit
         assign step[s][j] = amt[j / CHUNK_W][s];
      end
   end

   assign stage_data[0] = opa_i;

   for (genvar s = 0; s < SHW; s++) begin : g_stage
      psh_stage #(
         .WIDTH (WIDTH),
         .STAGE (s)
      ) u_stage (
         .din_i       (stage_data[s]),
         .step_i      (step[s]),
         .pos_i       (pos),
         .lane_w_i    (lane_w),
         .dir_right_i (dir_right_i),
         .dout_o      (stage_data[s+1])
      );
   end

   assign result_o = stage_data[SHW];

   // ---------------- assertions ----------------
   always_comb begin
      if (opa_i == '0)
         p_zero_data_r8: assert (result_o == '0)
            else $error("zero data produced %h", result_o);
      if (amt == '0)
         p_zero_count_r8: assert (result_o == opa_i)
            else $error("zero counts changed data %h -> %h", opa_i, result_o);
      if (cfg == LCFG_FULL)
         p_full_no_gain_r7: assert ($countones(result_o) <= $countones(opa_i))
            else $error("single lane gained set bits");
   end

   for (genvar h = 0; h < 2; h++) begin : g_half_chk
      always_comb begin
         if (cfg == LCFG_HALF)
            p_half_no_leak_r7: assert ($countones(result_o[h*HALF +: HALF])
                                       <= $countones(opa_i[h*HALF +: HALF]))
               else $error("half lane %0d received foreign bits", h);
      end
   end

   for (genvar c = 0; c < N_CHUNKS; c++) begin : g_chunk_chk
      always_comb begin
         if (cfg == LCFG_CHUNK)
            p_chunk_no_leak_r7: assert ($countones(result_o[c*CHUNK_W +: CHUNK_W])
                                        <= $countones(opa_i[c*CHUNK_W +: CHUNK_W]))
               else $error("chunk lane %0d received foreign bits", c);
      end
   end

endmodule

// File: tb/psh_shifter_tb_top.sv
module psh_shifter_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] opa;
   logic [15:0] opb;
   logic [2:0]  part;
   logic        dir_right;
   logic        scalar;
   logic [15:0] result;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   psh_shifter dut_i (
      .opa_i       (opa),
      .opb_i       (opb),
      .part_i      (part),
      .dir_right_i (dir_right),
      .scalar_i    (scalar),
      .result_o    (result)
   );

   // Lane-by-lane arithmetic model.
   function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b,
                                         logic [2:0] code, logic dr, logic sc);
      int lw;
      int lane;
      int amt;
      int sh;
      logic [15:0] r;
      r  = '0;
      lw = (code == 3'b111) ? 4 : (code == 3'b010) ? 8 : 16;
      for (int lo = 0; lo < 16; lo += lw) begin
         lane = (int'(a) >> lo) & ((1 << lw) - 1);
         amt  = sc ? (int'(b) & (lw - 1)) : ((int'(b) >> lo) & (lw - 1));
         sh   = dr ? (lane >> amt) : ((lane << amt) & ((1 << lw) - 1));
         r    = r | 16'(sh << lo);
      end
      return r;
   endfunction

   task automatic run(input logic [15:0] a, input logic [15:0] b,
                      input logic [2:0] code, input logic dr, input logic sc,
                      input string tag, input logic [15:0] exp);
      @(posedge clk);
      #1;
      opa = a; opb = b; part = code; dir_right = dr; scalar = sc;
      @(negedge clk);
      n_vec++;
      if (result !== exp) begin
         n_bad++;
         $display("FAIL %s: a=%h b=%h code=%b right=%0b common=%0b actual=%h expected=%h",
                  tag, a, b, code, dr, sc, result, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] pat [8];
      string tag;
      pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'h8001; pat[3] = 16'hA5C3;
      pat[4] = 16'h1234; pat[5] = 16'h0F0F; pat[6] = 16'hF0F0; pat[7] = 16'h5AA5;

      rst_n = 1'b0;
      opa = '0; opb = '0; part = '0; dir_right = 1'b0; scalar = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Idle state: zero in, zero out (R8).
      run(16'h0000, 16'h0000, 3'b000, 1'b0, 1'b0, "R8 idle", 16'h0000);

      // R7: bits never cross lane edges.
      run(16'hFFFF, 16'h0001, 3'b111, 1'b0, 1'b1, "R7 R1 chunk left", 16'hEEEE);
      run(16'hFFFF, 16'h0001, 3'b111, 1'b1, 1'b1, "R7 R2 chunk right", 16'h7777);
      run(16'h00FF, 16'h0007, 3'b010, 1'b0, 1'b1, "R7 R1 half left", 16'h0080);
      run(16'hFF00, 16'h0007, 3'b010, 1'b1, 1'b1, "R7 R2 half right", 16'h0100);

      // R5: count masking and per-lane sourcing.
      run(16'h0001, 16'h0013, 3'b000, 1'b0, 1'b0, "R5 mask 15", 16'h0008);
      run(16'h1111, 16'h3210, 3'b111, 1'b0, 1'b0, "R5 per-lane counts", 16'h8421);

      // R6: one common count, upper B bits ignored.
      run(16'h0101, 16'hFFF5, 3'b010, 1'b0, 1'b1, "R6 common count", 16'h2020);

      // R4: undefined code folds to one lane.
      run(16'h0001, 16'h000C, 3'b001, 1'b0, 1'b0, "R4 code 001", 16'h1000);

      // R8: zero counts pass data through.
      run(16'hA5C3, 16'h0000, 3'b111, 1'b1, 1'b0, "R8 zero count", 16'hA5C3);

      // Sweep every code, direction and mode.
      for (int code = 0; code < 8; code++) begin
         for (int dr = 0; dr < 2; dr++) begin
            for (int sc = 0; sc < 2; sc++) begin
               tag = $sformatf("%s %s %s", (dr != 0) ? "R2" : "R1",
                               (sc != 0) ? "R6" : "R5",
                               (code == 0 || code == 2 || code == 7) ? "R3" : "R4");
               for (int ai = 0; ai < 8; ai++) begin
                  for (int k = 0; k < 64; k++) begin
                     logic [15:0] bv;
                     bv = 16'(k * 40503 + k);
                     run(pat[ai], bv, 3'(code), 1'(dr), 1'(sc), tag,
                         model(pat[ai], bv, 3'(code), 1'(dr), 1'(sc)));
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule